// File: doc/BRIEF.md
# Stereo serial audio transmitter with repeat-on-underrun

This block sends stereo sample pairs over a three-wire I2S-style line. It does not make its own timing. The bit clock and the word-select clock come from an external master and are sampled as plain inputs in a fast system clock. The block looks for falling bit-clock edges and shifts one bit out on each one. The word select marks left (low) and right (high) slots of 32 bit periods each.

A producer writes left/right pairs at its own pace through a one-cycle load strobe. The pairs go into a pending register. The pending register moves to the active register only when a left slot begins, so both channels of a frame always come from the same pair. A frame may start with nothing new pending. This happens, for example, when the word clock runs at twice the producer rate. In that case the active pair is sent again, so the line never carries a gap or invalid data. A sticky error flag records the underrun until software clears it.

Top module: `i2s_rpt_tx`

## Requirements
- R1: While reset is held and just after it is released, `sdata` is 0 and `err_flag` is 0.
- R2: `fsync` low selects the left slot and `fsync` high selects the right slot. The 16-bit sample is sent MSB first. The MSB is driven on the first falling `sck` edge after the falling edge at which `fsync` changed, so the receiver sees it on the second rising edge after the change.
- R3: In each 32-period slot, the bit driven at the slot's first falling edge and the 15 bits after the sample are driven as 0.
- R4: `sdata` changes only in response to a falling `sck` edge. It is stable while `sck` is high.
- R5: A loaded pair is sent starting at the next left slot, which is an `fsync` high-to-low change. Both slots of that frame carry that pair. A load made during a frame does not alter the frame in progress.
- R6: If several pairs are loaded before a frame starts, the last one loaded is sent.
- R7: If a frame starts with no new pair pending, the previously sent pair is sent again in full.
- R8: A frame start with no pending pair sets `err_flag`. The flag stays set until cleared, and it is not set when fresh data was pending.
- R9: A one-cycle `err_clr` pulse returns `err_flag` to 0. If an underrun occurs in the same cycle, the set wins.
- R10: When the word clock runs at twice the load rate (one load per two frames), every pair appears on the line in two consecutive frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | External bit clock |
| fsync | input | 1 | External word select: 0 left, 1 right |
| ld_valid | input | 1 | One-cycle strobe that writes a pair into the pending register |
| ld_left | input | SAMPLE_W | Left sample to load |
| ld_right | input | SAMPLE_W | Right sample to load |
| err_clr | input | 1 | Clears the sticky underrun flag |
| sdata | output | 1 | Serial data, updated after falling `sck` edges |
| err_flag | output | 1 | Sticky underrun indicator |

## Verification
Several internal faults show up on the line within a single frame. A slot-position counter that is off by one moves every sample by one bit, so the first decoded word is wrong. A swapped channel select exchanges the left and right words. A transfer from the pending register at the wrong moment shows up as a frame whose two slots come from different pairs, or as a pair that appears one frame early or late. A wrong pending-valid state is seen at the next left slot, either as a missing repeat or as a spurious one. The error flag is checked a few bit periods after each frame start, so a flag that fails to set, sets falsely, or clears on its own is caught within that frame.

// File: rtl/i2s_rpt_pkg.sv
// Shared definitions for the repeat-on-underrun serial audio transmitter.
package i2s_rpt_pkg;

    // Channel selected by the word-select level.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Word-select level after reset; a later drop to CH_LEFT opens the first frame.
    localparam logic WS_IDLE = CH_RIGHT;

endpackage

// File: rtl/i2s_rpt_sync.sv
// Brings the external bit clock and word select into the system clock domain.
// It produces a one-cycle strobe for each falling bit-clock edge.
// Assumes: clk runs at least several times faster than sck; STAGES = 0 means
// the inputs are already synchronous to clk.
module i2s_rpt_sync
    import i2s_rpt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic ws_in,
    output logic sck_fall,
    output logic ws_s
);

    logic sck_s;
    logic sck_d;

    generate
        if (STAGES == 0) begin : g_direct
            assign sck_s = sck_in;
            assign ws_s  = ws_in;
        end else begin : g_chain
            logic [STAGES-1:0] sck_pipe;
            logic [STAGES-1:0] ws_pipe;

            // First stage captures the raw external levels.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sck_pipe[0] <= 1'b0;
                    ws_pipe[0]  <= WS_IDLE;
                end else begin
                    sck_pipe[0] <= sck_in;
                    ws_pipe[0]  <= ws_in;
                end
            end

            for (genvar k = 1; k < STAGES; k++) begin : g_stage
                // Further stages settle any metastable capture.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        sck_pipe[k] <= 1'b0;
                        ws_pipe[k]  <= WS_IDLE;
                    end else begin
                        sck_pipe[k] <= sck_pipe[k-1];
                        ws_pipe[k]  <= ws_pipe[k-1];
                    end
                end
            end

            assign sck_s = sck_pipe[STAGES-1];
            assign ws_s  = ws_pipe[STAGES-1];
        end
    endgenerate

    // Remember the previous bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_fall = sck_d & ~sck_s;

endmodule

// File: rtl/i2s_rpt_buf.sv
// Two-level sample store: a pending pair written by the producer and an
// active pair read by the serializer. The pending pair moves to active only
// at a frame start. With nothing pending, active keeps its value, which makes
// the line repeat it.
// Assumes: frame_start is a one-cycle strobe.
module i2s_rpt_buf #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_valid,
    input  logic [SAMPLE_W-1:0] ld_left,
    input  logic [SAMPLE_W-1:0] ld_right,
    input  logic                frame_start,
    output logic [SAMPLE_W-1:0] act_left,
    output logic [SAMPLE_W-1:0] act_right,
    output logic                pend_valid,
    output logic                underrun
);

    logic [SAMPLE_W-1:0] pend_left;
    logic [SAMPLE_W-1:0] pend_right;

    // Producer writes; the last write before a frame start wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_left  <= '0;
            pend_right <= '0;
        end else if (ld_valid) begin
            pend_left  <= ld_left;
            pend_right <= ld_right;
        end
    end

    // Pending is valid from a write until the frame start that consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_valid <= 1'b0;
        else        pend_valid <= ld_valid | (pend_valid & ~frame_start);
    end

    // Active pair changes only at a frame start that finds fresh data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_left  <= '0;
            act_right <= '0;
        end else if (frame_start && pend_valid) begin
            act_left  <= pend_left;
            act_right <= pend_right;
        end
    end

    assign underrun = frame_start & ~pend_valid;

endmodule

// File: rtl/i2s_rpt_ser.sv
// Slot serializer. On each falling bit-clock strobe it moves the slot
// position forward and drives one bit. A word-select change restarts the
// position. Position 0 is a zero pad, positions 1..SAMPLE_W carry the sample
// MSB first, and the rest are zero.
// Assumes: SLOT_W is a power of two and greater than SAMPLE_W + 1.
module i2s_rpt_ser
    import i2s_rpt_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SLOT_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_fall,
    input  logic                ws_s,
    input  logic [SAMPLE_W-1:0] word_left,
    input  logic [SAMPLE_W-1:0] word_right,
    output logic                frame_start,
    output logic                sdata
);

    localparam int                POS_W   = $clog2(SLOT_W);
    localparam int                PAD_W   = SLOT_W - SAMPLE_W - 1;
    localparam logic [POS_W-1:0]  POS_END = POS_W'(SLOT_W - 1);

    logic                ws_prev;
    logic [POS_W-1:0]    pos;
    logic [POS_W-1:0]    next_pos;
    logic [POS_W-1:0]    idx;
    logic                ws_edge;
    logic [SAMPLE_W-1:0] word;
    logic [SLOT_W-1:0]   slot_vec;
    logic                next_bit;

    assign ws_edge     = sck_fall && (ws_s != ws_prev);
    assign frame_start = ws_edge && (ws_s == CH_LEFT);

    // Next slot position: restart on a select change, otherwise step and hold at the end.
    always_comb begin
        if (ws_edge)             next_pos = '0;
        else if (pos == POS_END) next_pos = pos;
        else                     next_pos = pos + 1'b1;
    end

    // Lay the sample out in slot order and pick the bit for the next position.
    always_comb begin
        word     = (ws_s == CH_RIGHT) ? word_right : word_left;
        slot_vec = {1'b0, word, {PAD_W{1'b0}}};
        idx      = POS_END - next_pos;
        next_bit = slot_vec[idx];
    end

    // State moves only on falling bit-clock strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev <= WS_IDLE;
            pos     <= POS_END;
            sdata   <= 1'b0;
        end else if (sck_fall) begin
            ws_prev <= ws_s;
            pos     <= next_pos;
            sdata   <= next_bit;
        end
    end

endmodule

// File: rtl/i2s_rpt_tx.sv
// Top of the repeat-on-underrun serial audio transmitter. The external bit
// clock and word select drive all timing. The producer loads pairs at its own
// rate. A frame with no new pair repeats the old one and sets a sticky flag.
// Assumes: sck and fsync come from one master and change together on falling sck.
module i2s_rpt_tx #(
    parameter int SAMPLE_W    = 16,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic                fsync,
    input  logic                ld_valid,
    input  logic [SAMPLE_W-1:0] ld_left,
    input  logic [SAMPLE_W-1:0] ld_right,
    input  logic                err_clr,
    output logic                sdata,
    output logic                err_flag
);

    logic                sck_fall;
    logic                ws_s;
    logic                frame_start;
    logic                pend_valid;
    logic                underrun;
    logic [SAMPLE_W-1:0] act_left;
    logic [SAMPLE_W-1:0] act_right;

    i2s_rpt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck),
        .ws_in    (fsync),
        .sck_fall (sck_fall),
        .ws_s     (ws_s)
    );

    i2s_rpt_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (ld_valid),
        .ld_left     (ld_left),
        .ld_right    (ld_right),
        .frame_start (frame_start),
        .act_left    (act_left),
        .act_right   (act_right),
        .pend_valid  (pend_valid),
        .underrun    (underrun)
    );

    i2s_rpt_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_fall    (sck_fall),
        .ws_s        (ws_s),
        .word_left   (act_left),
        .word_right  (act_right),
        .frame_start (frame_start),
        .sdata       (sdata)
    );

    // Sticky underrun flag; a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (underrun) err_flag <= 1'b1;
        else if (err_clr)  err_flag <= 1'b0;
    end

endmodule

// File: rtl/i2s_rpt_chk.sv
// Property checker for i2s_rpt_tx, attached with bind below.
module i2s_rpt_chk (
    input logic clk,
    input logic rst_n,
    input logic sck_fall,
    input logic sdata,
    input logic err_flag,
    input logic err_clr,
    input logic underrun,
    input logic frame_start,
    input logic pend_valid,
    input logic ld_valid
);

    // R4
    sdata_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $past(sck_fall));

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> err_flag);

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !underrun) |=> !err_flag);

    // R6
    pend_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> pend_valid);

    // R5
    pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && pend_valid && !ld_valid) |=> !pend_valid);

endmodule

bind i2s_rpt_tx i2s_rpt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_fall    (sck_fall),
    .sdata       (sdata),
    .err_flag    (err_flag),
    .err_clr     (err_clr),
    .underrun    (underrun),
    .frame_start (frame_start),
    .pend_valid  (pend_valid),
    .ld_valid    (ld_valid)
);

// File: tb/sim_i2s_rpt_tx.sv
`timescale 1ns/1ps
module sim_i2s_rpt_tx;

    typedef struct {
        logic [15:0] l;
        logic [15:0] r;
        string       tag;
    } pair_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b1;
    logic        fsync = 1'b1;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_left = '0;
    logic [15:0] ld_right = '0;
    logic        err_clr = 1'b0;
    logic        sdata;
    logic        err_flag;

    int n_cmp = 0;
    int n_bad = 0;

    pair_t       exp_q[$];
    logic [15:0] hold_l = '0, hold_r = '0;
    logic [15:0] pend_l = '0, pend_r = '0;
    bit          pend_v = 0;
    bit          err_exp = 0;

    always #2.5 clk = ~clk;

    i2s_rpt_tx u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .fsync(fsync),
        .ld_valid(ld_valid), .ld_left(ld_left), .ld_right(ld_right),
        .err_clr(err_clr), .sdata(sdata), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // One bit-clock period: fall (with word select) then rise, 12 clk total.
    task automatic bit_period(input logic ws_v);
        @(negedge clk);
        sck = 1'b0;
        fsync = ws_v;
        repeat (6) @(negedge clk);
        sck = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] l, input logic [15:0] r);
        @(negedge clk);
        ld_valid = 1'b1; ld_left = l; ld_right = r;
        pend_l = l; pend_r = r; pend_v = 1;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        err_exp = 0;
        repeat (2) @(negedge clk);
        chk(err_flag == 1'b0, "R9 flag after clear pulse", {31'd0, err_flag}, 32'd0);
    endtask

    // Driver: model the frame-start transfer, push the expected pair, run 64 periods.
    task automatic frame(input bit mid_ld, input logic [15:0] ml, input logic [15:0] mr,
                         input string tag);
        pair_t e;
        if (pend_v) begin
            hold_l = pend_l; hold_r = pend_r; pend_v = 0;
        end else begin
            err_exp = 1;
        end
        e.l = hold_l; e.r = hold_r; e.tag = tag;
        exp_q.push_back(e);
        for (int p = 0; p < 64; p++) begin
            bit_period(p < 32 ? 1'b0 : 1'b1);
            if (p == 4)
                chk(err_flag == err_exp, "R8 flag after frame start",
                    {31'd0, err_flag}, {31'd0, err_exp});
            if (p == 10 && mid_ld) load(ml, mr);
        end
    endtask

    // Monitor: rebuild slots at rising bit-clock edges and compare against the queue.
    logic        mon_ws = 1'b1;
    int          mon_cnt = 0;
    logic [15:0] mon_word = '0;
    logic [15:0] cap_l = '0;
    bit          have_l = 0;
    logic        rise_val = 1'b0;
    bit          armed = 0;

    initial begin
        forever begin
            @(posedge sck);
            if (rst_n) begin
                rise_val = sdata;
                armed = 1;
                if (fsync != mon_ws) begin
                    chk(sdata == 1'b0, "R3 pad at slot edge", {31'd0, sdata}, 32'd0);
                    if (mon_cnt == 31) begin
                        if (mon_ws == 1'b0) begin
                            cap_l = mon_word; have_l = 1;
                        end else if (have_l) begin
                            have_l = 0;
                            if (exp_q.size() == 0) begin
                                chk(0, "R5 frame with no expected pair", {cap_l, mon_word}, 32'd0);
                            end else begin
                                pair_t e;
                                e = exp_q.pop_front();
                                chk(cap_l == e.l, {e.tag, " left word (R2)"}, {16'd0, cap_l}, {16'd0, e.l});
                                chk(mon_word == e.r, {e.tag, " right word (R2)"}, {16'd0, mon_word}, {16'd0, e.r});
                            end
                        end
                    end
                    mon_cnt = 0;
                    mon_word = '0;
                    mon_ws = fsync;
                end else begin
                    if (mon_cnt < 31) mon_cnt++;
                    if (mon_cnt <= 16) mon_word[16-mon_cnt] = sdata;
                    else chk(sdata == 1'b0, "R3 pad after sample", {31'd0, sdata}, 32'd0);
                end
            end
        end
    end

    // Monitor: data must not move while the bit clock is high.
    initial begin
        forever begin
            @(negedge sck);
            if (rst_n && armed)
                chk(sdata == rise_val, "R4 sdata stable while sck high",
                    {31'd0, sdata}, {31'd0, rise_val});
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before the sequence ended");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(sdata == 1'b0, "R1 sdata in reset", {31'd0, sdata}, 32'd0);
        chk(err_flag == 1'b0, "R1 err_flag in reset", {31'd0, err_flag}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sdata == 1'b0, "R1 sdata after reset", {31'd0, sdata}, 32'd0);
        chk(err_flag == 1'b0, "R1 err_flag after reset", {31'd0, err_flag}, 32'd0);

        for (int i = 0; i < 4; i++) bit_period(1'b1);

        load(16'hA5C3, 16'h3C5A);
        frame(0, '0, '0, "R5 first pair");
        load(16'h1234, 16'h5678);
        load(16'hFEDC, 16'h0181);
        frame(0, '0, '0, "R6 latest load");
        frame(1, 16'h8001, 16'h7FFE, "R7 repeat on underrun");
        clear_err();
        frame(0, '0, '0, "R5 mid-frame load sent next");
        load(16'hC0DE, 16'hBEEF);
        frame(0, '0, '0, "R10 first copy");
        frame(0, '0, '0, "R10 second copy");
        clear_err();
        load(16'hFFFF, 16'h0000);
        frame(0, '0, '0, "R10 first copy");
        frame(0, '0, '0, "R10 second copy");

        for (int i = 0; i < 3; i++) bit_period(1'b0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all expected frames seen",
            exp_q.size(), 32'd0);
        summary();
        $finish;
    end

endmodule